// File: doc/BRIEF.md
# Flow-Controlled Interface Register File

This block holds a small bank of word registers that sits between the router pipelines and a host processor. Each register has an occupancy bit. A flow-controlled write goes through only when the register is empty. A flow-controlled read goes through only when it is occupied, and it empties the register. Blind accesses ignore the occupancy bit for their own success: a blind write always stores and marks the register occupied, and a blind read always returns the contents and leaves the bit unchanged. The block can therefore act as a handshaked mailbox or as a plain scratch register, chosen per access and in either direction.

In one cycle, every pipeline may read in its read stage and write in its write stage, and the host may read and write as well. Each access gets a success bit in the same cycle, so a flow-controlled move can stall and retry. A pipeline may make only one access per cycle. If it presents both a read and a write, the block flags a conflict and refuses both. Several writers aimed at one register are ordered by fixed priority: lower-numbered pipelines come first and the host comes last. Several flow-controlled readers of one register are ordered the same way.

Top module: `flow_ifreg_file`

## Requirements
- R1: After reset every register holds zero and is empty. A blind read returns 0 and a flow-controlled read is refused.
- R2: A blind write that wins arbitration succeeds even when the register is occupied. It stores its data and marks the register occupied.
- R3: A flow-controlled write succeeds only when the target is empty. When refused, the stored data and the occupancy bit are unchanged.
- R4: A flow-controlled read succeeds only when the target is occupied and then empties it. On an empty target it is refused.
- R5: A blind read that is not in conflict always succeeds. It returns the current contents and leaves the occupancy bit unchanged.
- R6: The success bits and the read data are valid in the same cycle as the request. A successful write is visible to reads from the next cycle on.
- R7: A read and a write to the same register in the same cycle: the read returns the value held before that cycle.
- R8: A pipeline that requests a read and a write in one cycle raises its conflict output. Both of its accesses are refused and neither changes any register.
- R9: When several writers target one register in a cycle, the lowest-numbered pipeline wins and the host ranks last. All other writers to that register are refused.
- R10: When several flow-controlled readers target one occupied register in a cycle, only the lowest-numbered pipeline (host last) succeeds.
- R11: Accesses by different requesters to different registers in the same cycle all proceed independently.
- R12: A successful write and a successful flow-controlled read of one register in the same cycle leave it occupied with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_rd_req | input | NUM_PIPES | Read request per pipeline (read stage) |
| p_rd_flow | input | NUM_PIPES | Pipeline read is flow-controlled |
| p_rd_idx | input | NUM_PIPES x IW | Register index of pipeline read |
| p_rd_data | output | NUM_PIPES x DATA_W | Read data per pipeline |
| p_rd_ok | output | NUM_PIPES | Pipeline read succeeded |
| p_wr_req | input | NUM_PIPES | Write request per pipeline (write stage) |
| p_wr_flow | input | NUM_PIPES | Pipeline write is flow-controlled |
| p_wr_idx | input | NUM_PIPES x IW | Register index of pipeline write |
| p_wr_data | input | NUM_PIPES x DATA_W | Pipeline write data |
| p_wr_ok | output | NUM_PIPES | Pipeline write succeeded |
| p_conflict | output | NUM_PIPES | Pipeline attempted two accesses in one cycle |
| h_rd_req | input | 1 | Host read request |
| h_rd_flow | input | 1 | Host read is flow-controlled |
| h_rd_idx | input | IW | Host read index |
| h_rd_data | output | DATA_W | Host read data |
| h_rd_ok | output | 1 | Host read succeeded |
| h_wr_req | input | 1 | Host write request |
| h_wr_flow | input | 1 | Host write is flow-controlled |
| h_wr_idx | input | IW | Host write index |
| h_wr_data | input | DATA_W | Host write data |
| h_wr_ok | output | 1 | Host write succeeded |

## Verification
The occupancy logic is exercised with both access kinds against empty and occupied registers. This separates a design that gates success on the occupancy bit from one that ignores it, or one that clears the bit on a blind read. Same-cycle patterns follow: a write with a read of the same register, three writers on one register, three flow-controlled readers on one register, and three requesters on disjoint registers. These show whether old-value read-through, the fixed priority order (with the host last) and independence across registers hold. A pipeline issuing both of its accesses checks that the conflict flag is raised and that the register stays untouched afterwards.

// File: rtl/ifreg_pkg.sv
package ifreg_pkg;

    localparam int DEF_REGS   = 16;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_PIPES  = 2;

    // What kind of access a requester presents this cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_BLIND = 2'd1,
        ACC_FLOW  = 2'd2
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic req, input logic flow);
        if (!req)
            return ACC_IDLE;
        return flow ? ACC_FLOW : ACC_BLIND;
    endfunction

    // Whether an access of the given kind may proceed given occupancy.
    // Writes need an empty register, reads need an occupied one (flow only).
    function automatic logic occupancy_allows(input acc_kind_e kind,
                                              input logic is_write,
                                              input logic full);
        case (kind)
            ACC_BLIND: return 1'b1;
            ACC_FLOW:  return is_write ? !full : full;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ifreg_prio_pick.sv
// Fixed-priority pick: grants the lowest-numbered active request.
module ifreg_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ifreg_store.sv
// Register words with their occupancy bits. Set takes precedence over clear.
module ifreg_store #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en   [NUM_REGS],
    input  logic [DATA_W-1:0] set_data [NUM_REGS],
    input  logic              clr_en   [NUM_REGS],
    output logic [DATA_W-1:0] q_data   [NUM_REGS],
    output logic              q_full   [NUM_REGS]
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                q_data[r] <= '0;
                q_full[r] <= 1'b0;
            end else begin
                if (set_en[r]) begin
                    q_data[r] <= set_data[r];
                    q_full[r] <= 1'b1;
                end else if (clr_en[r]) begin
                    q_full[r] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/flow_ifreg_file.sv
module flow_ifreg_file
    import ifreg_pkg::*;
#(
    parameter  int NUM_REGS  = DEF_REGS,
    parameter  int DATA_W    = DEF_DATA_W,
    parameter  int NUM_PIPES = DEF_PIPES,
    localparam int IW        = $clog2(NUM_REGS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_PIPES-1:0]            p_rd_req,
    input  logic [NUM_PIPES-1:0]            p_rd_flow,
    input  logic [NUM_PIPES-1:0][IW-1:0]    p_rd_idx,
    output logic [NUM_PIPES-1:0][DATA_W-1:0] p_rd_data,
    output logic [NUM_PIPES-1:0]            p_rd_ok,
    input  logic [NUM_PIPES-1:0]            p_wr_req,
    input  logic [NUM_PIPES-1:0]            p_wr_flow,
    input  logic [NUM_PIPES-1:0][IW-1:0]    p_wr_idx,
    input  logic [NUM_PIPES-1:0][DATA_W-1:0] p_wr_data,
    output logic [NUM_PIPES-1:0]            p_wr_ok,
    output logic [NUM_PIPES-1:0]            p_conflict,
    input  logic                            h_rd_req,
    input  logic                            h_rd_flow,
    input  logic [IW-1:0]                   h_rd_idx,
    output logic [DATA_W-1:0]               h_rd_data,
    output logic                            h_rd_ok,
    input  logic                            h_wr_req,
    input  logic                            h_wr_flow,
    input  logic [IW-1:0]                   h_wr_idx,
    input  logic [DATA_W-1:0]               h_wr_data,
    output logic                            h_wr_ok
);
    // Requesters: pipelines 0..NUM_PIPES-1, host in the last (lowest) slot
    localparam int NA   = NUM_PIPES + 1;
    localparam int HOST = NUM_PIPES;

    acc_kind_e         w_kind [NA];
    logic [IW-1:0]     w_idx  [NA];
    logic [DATA_W-1:0] w_data [NA];
    logic              w_ok   [NA];
    acc_kind_e         r_kind [NA];
    logic [IW-1:0]     r_idx  [NA];
    logic              r_ok   [NA];

    logic [NA-1:0]     wreq   [NUM_REGS];
    logic [NA-1:0]     wgrant [NUM_REGS];
    logic [NA-1:0]     freq   [NUM_REGS];
    logic [NA-1:0]     fgrant [NUM_REGS];

    logic              set_en   [NUM_REGS];
    logic [DATA_W-1:0] set_data [NUM_REGS];
    logic              clr_en   [NUM_REGS];
    logic [DATA_W-1:0] q_data   [NUM_REGS];
    logic              q_full   [NUM_REGS];

    // One access per pipeline per cycle: a double request is a conflict
    assign p_conflict = p_rd_req & p_wr_req;

    // Gather requesters into uniform arrays
    always_comb begin
        for (int i = 0; i < NUM_PIPES; i++) begin
            w_kind[i] = classify(p_wr_req[i] && !p_conflict[i], p_wr_flow[i]);
            w_idx[i]  = p_wr_idx[i];
            w_data[i] = p_wr_data[i];
            r_kind[i] = classify(p_rd_req[i] && !p_conflict[i], p_rd_flow[i]);
            r_idx[i]  = p_rd_idx[i];
        end
        w_kind[HOST] = classify(h_wr_req, h_wr_flow);
        w_idx[HOST]  = h_wr_idx;
        w_data[HOST] = h_wr_data;
        r_kind[HOST] = classify(h_rd_req, h_rd_flow);
        r_idx[HOST]  = h_rd_idx;
    end

    // Per-register arbitration for writers and for flow-controlled readers
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_arb
        always_comb begin
            for (int i = 0; i < NA; i++) begin
                wreq[r][i] = (w_kind[i] != ACC_IDLE) && (w_idx[i] == IW'(r));
                freq[r][i] = (r_kind[i] == ACC_FLOW) && (r_idx[i] == IW'(r));
            end
        end

        ifreg_prio_pick #(.N(NA)) u_wpick (
            .req   (wreq[r]),
            .grant (wgrant[r])
        );

        ifreg_prio_pick #(.N(NA)) u_rpick (
            .req   (freq[r]),
            .grant (fgrant[r])
        );
    end

    // Success decisions against the occupancy held at the start of the cycle
    always_comb begin
        for (int i = 0; i < NA; i++) begin
            w_ok[i] = (w_kind[i] != ACC_IDLE)
                      && wgrant[w_idx[i]][i]
                      && occupancy_allows(w_kind[i], 1'b1, q_full[w_idx[i]]);
            case (r_kind[i])
                ACC_BLIND: r_ok[i] = 1'b1;
                ACC_FLOW:  r_ok[i] = fgrant[r_idx[i]][i]
                                     && occupancy_allows(ACC_FLOW, 1'b0, q_full[r_idx[i]]);
                default:   r_ok[i] = 1'b0;
            endcase
        end
    end

    // Update commands for the storage
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_upd
        always_comb begin
            set_en[r]   = 1'b0;
            set_data[r] = '0;
            clr_en[r]   = 1'b0;
            for (int i = 0; i < NA; i++) begin
                if (w_ok[i] && (w_idx[i] == IW'(r))) begin
                    set_en[r]   = 1'b1;
                    set_data[r] = w_data[i];
                end
                if (r_ok[i] && (r_kind[i] == ACC_FLOW) && (r_idx[i] == IW'(r)))
                    clr_en[r] = 1'b1;
            end
        end
    end

    ifreg_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_data (set_data),
        .clr_en   (clr_en),
        .q_data   (q_data),
        .q_full   (q_full)
    );

    // Outputs: read data is the registered value, so same-cycle writes are not seen
    always_comb begin
        for (int i = 0; i < NUM_PIPES; i++) begin
            p_rd_data[i] = q_data[p_rd_idx[i]];
            p_rd_ok[i]   = r_ok[i];
            p_wr_ok[i]   = w_ok[i];
        end
        h_rd_data = q_data[h_rd_idx];
        h_rd_ok   = r_ok[HOST];
        h_wr_ok   = w_ok[HOST];
    end

endmodule

// File: rtl/flow_ifreg_checker.sv
module flow_ifreg_checker #(
    parameter int NUM_PIPES = 2,
    parameter int IW        = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_PIPES-1:0]         p_rd_req,
    input logic [NUM_PIPES-1:0]         p_rd_flow,
    input logic [NUM_PIPES-1:0][IW-1:0] p_rd_idx,
    input logic [NUM_PIPES-1:0]         p_rd_ok,
    input logic [NUM_PIPES-1:0]         p_wr_req,
    input logic [NUM_PIPES-1:0][IW-1:0] p_wr_idx,
    input logic [NUM_PIPES-1:0]         p_wr_ok,
    input logic [NUM_PIPES-1:0]         p_conflict,
    input logic                         h_wr_req,
    input logic [IW-1:0]                h_wr_idx,
    input logic                         h_wr_ok
);
    for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
        // R8: a double request refuses both accesses
        p_conflict_refuse_r8: assert property (@(posedge clk) disable iff (rst)
            (p_rd_req[i] && p_wr_req[i]) |-> (p_conflict[i] && !p_rd_ok[i] && !p_wr_ok[i]));

        // R5: a blind read outside a conflict always succeeds
        p_blind_read_r5: assert property (@(posedge clk) disable iff (rst)
            (p_rd_req[i] && !p_rd_flow[i] && !p_wr_req[i]) |-> p_rd_ok[i]);

        // R9: the host yields to any pipeline writing the same register
        p_host_yield_r9: assert property (@(posedge clk) disable iff (rst)
            (p_wr_req[i] && !p_rd_req[i] && h_wr_req && (h_wr_idx == p_wr_idx[i]))
            |-> !h_wr_ok);

        if (i > 0) begin : g_hi
            // R9: pipeline 0 outranks higher pipelines on the same register
            p_write_prio_r9: assert property (@(posedge clk) disable iff (rst)
                (p_wr_req[0] && !p_rd_req[0] && p_wr_req[i] && !p_rd_req[i]
                 && (p_wr_idx[i] == p_wr_idx[0])) |-> !p_wr_ok[i]);

            // R10: only one flow-controlled reader of a register succeeds
            p_read_prio_r10: assert property (@(posedge clk) disable iff (rst)
                (p_rd_req[0] && p_rd_flow[0] && !p_wr_req[0]
                 && p_rd_req[i] && p_rd_flow[i] && !p_wr_req[i]
                 && (p_rd_idx[i] == p_rd_idx[0])) |-> !p_rd_ok[i]);
        end
    end
endmodule

bind flow_ifreg_file flow_ifreg_checker #(.NUM_PIPES(NUM_PIPES), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .p_rd_req   (p_rd_req),
    .p_rd_flow  (p_rd_flow),
    .p_rd_idx   (p_rd_idx),
    .p_rd_ok    (p_rd_ok),
    .p_wr_req   (p_wr_req),
    .p_wr_idx   (p_wr_idx),
    .p_wr_ok    (p_wr_ok),
    .p_conflict (p_conflict),
    .h_wr_req   (h_wr_req),
    .h_wr_idx   (h_wr_idx),
    .h_wr_ok    (h_wr_ok)
);

// File: tb/flow_ifreg_file_test.sv
module flow_ifreg_file_test;

    localparam int P  = 2;
    localparam int DW = 32;
    localparam int IW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [P-1:0]      p_rd_req, p_rd_flow, p_rd_ok;
    logic [P-1:0][IW-1:0] p_rd_idx, p_wr_idx;
    logic [P-1:0][DW-1:0] p_rd_data, p_wr_data;
    logic [P-1:0]      p_wr_req, p_wr_flow, p_wr_ok, p_conflict;
    logic              h_rd_req, h_rd_flow, h_rd_ok;
    logic [IW-1:0]     h_rd_idx, h_wr_idx;
    logic [DW-1:0]     h_rd_data, h_wr_data;
    logic              h_wr_req, h_wr_flow, h_wr_ok;

    int checks = 0;
    int bad    = 0;

    always #2 clk = ~clk;

    flow_ifreg_file #(.NUM_REGS(16), .DATA_W(DW), .NUM_PIPES(P)) uut (.*);

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        p_rd_req = '0; p_rd_flow = '0; p_rd_idx = '0;
        p_wr_req = '0; p_wr_flow = '0; p_wr_idx = '0; p_wr_data = '0;
        h_rd_req = 0; h_rd_flow = 0; h_rd_idx = '0;
        h_wr_req = 0; h_wr_flow = 0; h_wr_idx = '0; h_wr_data = '0;
    endtask

    // Commit the current cycle and return to a quiet point before the next edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic host_read(input logic [IW-1:0] idx, input logic flow,
                             input logic exp_ok, input logic [DW-1:0] exp_data,
                             input string tag);
        h_rd_req = 1; h_rd_flow = flow; h_rd_idx = idx;
        settle();
        check({tag, " host read ok"}, 32'(h_rd_ok), 32'(exp_ok));
        if (exp_ok) check({tag, " host read data"}, h_rd_data, exp_data);
        step();
    endtask

    task automatic host_write(input logic [IW-1:0] idx, input logic flow,
                              input logic [DW-1:0] data, input logic exp_ok,
                              input string tag);
        h_wr_req = 1; h_wr_flow = flow; h_wr_idx = idx; h_wr_data = data;
        settle();
        check({tag, " host write ok"}, 32'(h_wr_ok), 32'(exp_ok));
        step();
    endtask

    task automatic t_reset();
        host_read(4'd3, 0, 1, 32'h0, "R1 R5");
        host_read(4'd3, 1, 0, 32'h0, "R1 R4");
    endtask

    task automatic t_blind_then_drain();
        p_wr_req[0] = 1; p_wr_idx[0] = 4'd2; p_wr_data[0] = 32'hA5;
        settle();
        check("R2 blind write ok", 32'(p_wr_ok[0]), 32'd1);
        step();
        host_read(4'd2, 0, 1, 32'hA5, "R2 R6");
        host_read(4'd2, 0, 1, 32'hA5, "R5 flag kept");
        host_write(4'd2, 0, 32'hB6, 1, "R2 blind over full");
        host_read(4'd2, 1, 1, 32'hB6, "R4 drain");
        host_read(4'd2, 1, 0, 32'h0, "R4 now empty");
    endtask

    task automatic t_flow_write();
        host_write(4'd5, 1, 32'h11, 1, "R3 into empty");
        p_wr_req[1] = 1; p_wr_flow[1] = 1; p_wr_idx[1] = 4'd5; p_wr_data[1] = 32'h22;
        settle();
        check("R3 flow write into full refused", 32'(p_wr_ok[1]), 32'd0);
        step();
        p_rd_req[0] = 1; p_rd_flow[0] = 1; p_rd_idx[0] = 4'd5;
        settle();
        check("R3 flag kept ok", 32'(p_rd_ok[0]), 32'd1);
        check("R3 data kept", p_rd_data[0], 32'h11);
        step();
    endtask

    task automatic t_same_cycle();
        host_write(4'd7, 0, 32'h33, 1, "R12 setup");
        p_rd_req[0] = 1; p_rd_flow[0] = 1; p_rd_idx[0] = 4'd7;
        p_wr_req[1] = 1; p_wr_idx[1] = 4'd7; p_wr_data[1] = 32'h44;
        settle();
        check("R7 read ok", 32'(p_rd_ok[0]), 32'd1);
        check("R7 old value", p_rd_data[0], 32'h33);
        check("R12 write ok", 32'(p_wr_ok[1]), 32'd1);
        step();
        host_read(4'd7, 1, 1, 32'h44, "R12 stays full");
    endtask

    task automatic t_conflict();
        p_rd_req[1] = 1; p_rd_idx[1] = 4'd9;
        p_wr_req[1] = 1; p_wr_idx[1] = 4'd9; p_wr_data[1] = 32'h55;
        settle();
        check("R8 conflict flag", 32'(p_conflict[1]), 32'd1);
        check("R8 read refused", 32'(p_rd_ok[1]), 32'd0);
        check("R8 write refused", 32'(p_wr_ok[1]), 32'd0);
        check("R8 other pipe clear", 32'(p_conflict[0]), 32'd0);
        step();
        host_read(4'd9, 0, 1, 32'h0, "R8 untouched");
        host_read(4'd9, 1, 0, 32'h0, "R8 still empty");
    endtask

    task automatic t_write_prio();
        p_wr_req = 2'b11; p_wr_idx[0] = 4'd10; p_wr_idx[1] = 4'd10;
        p_wr_data[0] = 32'h1; p_wr_data[1] = 32'h2;
        h_wr_req = 1; h_wr_idx = 4'd10; h_wr_data = 32'h3;
        settle();
        check("R9 pipe0 wins", 32'(p_wr_ok[0]), 32'd1);
        check("R9 pipe1 refused", 32'(p_wr_ok[1]), 32'd0);
        check("R9 host refused", 32'(h_wr_ok), 32'd0);
        step();
        host_read(4'd10, 0, 1, 32'h1, "R9 winner data");
        p_wr_req[1] = 1; p_wr_idx[1] = 4'd11; p_wr_data[1] = 32'h66;
        h_wr_req = 1; h_wr_idx = 4'd11; h_wr_data = 32'h77;
        settle();
        check("R9 pipe1 over host", 32'(p_wr_ok[1]), 32'd1);
        check("R9 host last", 32'(h_wr_ok), 32'd0);
        step();
        host_read(4'd11, 0, 1, 32'h66, "R9 pipe1 data");
    endtask

    task automatic t_read_prio();
        host_write(4'd12, 0, 32'h88, 1, "R10 setup");
        p_rd_req = 2'b11; p_rd_flow = 2'b11; p_rd_idx[0] = 4'd12; p_rd_idx[1] = 4'd12;
        h_rd_req = 1; h_rd_flow = 1; h_rd_idx = 4'd12;
        settle();
        check("R10 pipe0 reads", 32'(p_rd_ok[0]), 32'd1);
        check("R10 pipe1 refused", 32'(p_rd_ok[1]), 32'd0);
        check("R10 host refused", 32'(h_rd_ok), 32'd0);
        step();
        host_read(4'd12, 1, 0, 32'h0, "R10 drained once");
    endtask

    task automatic t_parallel();
        p_wr_req = 2'b11; p_wr_idx[0] = 4'd13; p_wr_idx[1] = 4'd14;
        p_wr_data[0] = 32'hD0; p_wr_data[1] = 32'hE0; p_wr_flow = 2'b11;
        h_wr_req = 1; h_wr_flow = 1; h_wr_idx = 4'd15; h_wr_data = 32'hF0;
        settle();
        check("R11 pipe0 write", 32'(p_wr_ok[0]), 32'd1);
        check("R11 pipe1 write", 32'(p_wr_ok[1]), 32'd1);
        check("R11 host write", 32'(h_wr_ok), 32'd1);
        step();
        p_rd_req = 2'b11; p_rd_flow = 2'b11; p_rd_idx[0] = 4'd14; p_rd_idx[1] = 4'd15;
        h_rd_req = 1; h_rd_flow = 1; h_rd_idx = 4'd13;
        settle();
        check("R11 pipe0 read", p_rd_data[0], 32'hE0);
        check("R11 pipe1 read", p_rd_data[1], 32'hF0);
        check("R11 host read", h_rd_data, 32'hD0);
        check("R11 all ok", 32'({p_rd_ok, h_rd_ok}), 32'b111);
        step();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_blind_then_drain();
        t_flow_write();
        t_same_cycle();
        t_conflict();
        t_write_prio();
        t_read_prio();
        t_parallel();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule